// File: doc/BRIEF.md
# GHASH Hash-Key Precompute Unit

This block prepares the hash subkey for a carry-less-multiply GHASH engine. A one-cycle load strobe captures the 128-bit subkey. The block then produces three registered entries that the engine's multipliers read: the twisted key, a helper word, and the square of the twisted key.

The twisted key is the subkey with its 64-bit halves exchanged, then shifted left by one bit. If a bit leaves the top, a fixed constant is folded back in. The square uses a three-product Karatsuba carry-less multiply followed by a two-step 64-bit fold, which is the same arithmetic the hash engine applies per block. The helper word holds the XOR of the two halves of the twisted key and of the square, ready for the engine's middle Karatsuba product.

The computation is a three-stage pipeline. The valid flag drops on every load and rises once all three entries belong to the most recent load.

Top module: `hkey_precompute`

## Requirements
- R1: A synchronous active-high reset clears `key_valid`, `tw_key`, `helper_key` and `sq_key` to zero.
- R2: Let `s = {key_in[63:0], key_in[127:64]}`. `tw_key` equals `s` shifted left by one bit across all 128 bits, with bit 127 discarded. When `s[127]` (that is `key_in[63]`) is 1, the shifted value is XORed with `128'hC2000000000000000000000000000001`.
- R3: Bit i of a 128-bit value is the coefficient of x^i. `sq_key` equals `tw_key*tw_key*x^-128 mod Q`, with `Q = x^128+x^127+x^126+x^121+1`, fully reduced to degree below 128.
- R4: `helper_key[63:0]` equals `tw_key[63:0] ^ tw_key[127:64]`, and `helper_key[127:64]` equals `sq_key[63:0] ^ sq_key[127:64]`.
- R5: Let `load` be sampled high at rising edge k with no later load. `key_valid` is then high after edge k+2, with all three entries computed from the key given at edge k.
- R6: In the cycle after any edge where `load` is high, `key_valid` is low. A load that arrives while a computation is in flight restarts it, and the results belong to the last key loaded.
- R7: While `key_valid` is high and `load` is low, `key_valid` and all three entries hold their values. A change on `key_in` without `load` has no effect on them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| load | input | 1 | Capture strobe for `key_in` |
| key_in | input | 128 | Hash subkey; [127:64] is the first 64-bit word |
| key_valid | output | 1 | All three entries are ready |
| tw_key | output | 128 | Twisted subkey (entry 0) |
| helper_key | output | 128 | Packed half-XOR helper word (entry 1) |
| sq_key | output | 128 | Twisted subkey squared (entry 2) |

## Verification
The bench loads every one-hot subkey, so each single bit is checked as it moves through the half swap and the shift. The key with bit 63 set is the only single-bit case that exercises the constant fold, and high one-hot bits push the square into both fold steps. The all-zero key, the all-ones key and several dense mixed keys add cases where many partial products cancel. Separate cases cover a back-to-back reload, a key change without a load, a long hold, and reset in the middle of a computation. Together these separate wrong timing and a missing restart from wrong arithmetic.

// File: rtl/hkp_pkg.sv
package hkp_pkg;
  localparam int LANE = 64;
  localparam int BLK  = 2 * LANE;

  // fold multiplier: x^63 + x^62 + x^57
  localparam logic [LANE-1:0] FOLD_C  = {8'hC2, {(LANE-8){1'b0}}};
  // twist correction applied when the top bit leaves the block
  localparam logic [BLK-1:0]  TWIST_C = {8'hC2, {(BLK-16){1'b0}}, 8'h01};

  // 64x64 carry-less product
  function automatic logic [BLK-1:0] clmul(input logic [LANE-1:0] a,
                                           input logic [LANE-1:0] b);
    logic [BLK-1:0] acc;
    acc = '0;
    for (int i = 0; i < LANE; i++)
      if (b[i]) acc = acc ^ (BLK'(a) << i);
    return acc;
  endfunction

  function automatic logic [BLK-1:0] twist(input logic [BLK-1:0] k);
    logic [BLK-1:0] s;
    logic [BLK-1:0] t;
    s = {k[LANE-1:0], k[BLK-1:LANE]};
    t = {s[BLK-2:0], 1'b0};
    if (s[BLK-1]) t = t ^ TWIST_C;
    return t;
  endfunction

  function automatic logic [BLK-1:0] halves_xor(input logic [BLK-1:0] v);
    return BLK'(v[LANE-1:0] ^ v[BLK-1:LANE]);
  endfunction

  // Karatsuba recombination plus two 64-bit folds
  function automatic logic [BLK-1:0] reduce(input logic [BLK-1:0] plo,
                                            input logic [BLK-1:0] pmid,
                                            input logic [BLK-1:0] phi);
    logic [BLK-1:0] mid;
    logic [BLK-1:0] upper;
    logic [BLK-1:0] r1;
    mid   = pmid ^ plo ^ phi ^ {phi[LANE-1:0], plo[BLK-1:LANE]};
    upper = {phi[BLK-1:LANE], mid[BLK-1:LANE]};
    r1    = {plo[LANE-1:0], mid[LANE-1:0]} ^ clmul(plo[LANE-1:0], FOLD_C);
    return clmul(r1[LANE-1:0], FOLD_C) ^ {r1[LANE-1:0], r1[BLK-1:LANE]} ^ upper;
  endfunction
endpackage

// File: rtl/hkp_twist.sv
module hkp_twist
  import hkp_pkg::*;
(
  input  logic           clk,
  input  logic           rst,
  input  logic           load,
  input  logic [BLK-1:0] key_in,
  output logic           tw_v,
  output logic [BLK-1:0] tw_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      tw_v <= 1'b0;
      tw_q <= '0;
    end else begin
      tw_v <= load;
      if (load) tw_q <= twist(key_in);
    end
  end

  AST_TWIST_LSB: assert property (@(posedge clk) disable iff (rst)
    (load && !$past(rst)) |=> (tw_q[0] == $past(key_in[LANE-1])));  // R2
  AST_TWIST_SHIFT: assert property (@(posedge clk) disable iff (rst)
    load |=> (tw_q[LANE] == $past(key_in[BLK-1])));  // R2
endmodule

// File: rtl/hkp_square.sv
module hkp_square
  import hkp_pkg::*;
(
  input  logic           clk,
  input  logic           rst,
  input  logic           in_v,
  input  logic [BLK-1:0] tw_in,
  output logic           prod_v,
  output logic [BLK-1:0] tw_out,
  output logic [BLK-1:0] helper_out,
  output logic [BLK-1:0] sq_out
);
  localparam int NPROD = 3;  // low, high, middle

  logic [LANE-1:0] opnd [NPROD];
  logic [BLK-1:0]  prod_d [NPROD];
  logic [BLK-1:0]  prod_q [NPROD];
  logic [BLK-1:0]  tw_mid;
  logic [BLK-1:0]  sq_d;

  assign opnd[0] = tw_in[LANE-1:0];
  assign opnd[1] = tw_in[BLK-1:LANE];
  assign opnd[2] = tw_in[LANE-1:0] ^ tw_in[BLK-1:LANE];

  for (genvar g = 0; g < NPROD; g++) begin : g_prod
    assign prod_d[g] = clmul(opnd[g], opnd[g]);
    always_ff @(posedge clk) begin
      if (rst) prod_q[g] <= '0;
      else if (in_v) prod_q[g] <= prod_d[g];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prod_v <= 1'b0;
      tw_mid <= '0;
    end else begin
      prod_v <= in_v;
      if (in_v) tw_mid <= tw_in;
    end
  end

  assign sq_d = reduce(prod_q[0], prod_q[2], prod_q[1]);

  always_ff @(posedge clk) begin
    if (rst) begin
      tw_out     <= '0;
      sq_out     <= '0;
      helper_out <= '0;
    end else if (prod_v) begin
      tw_out     <= tw_mid;
      sq_out     <= sq_d;
      helper_out <= {halves_xor(sq_d)[LANE-1:0], halves_xor(tw_mid)[LANE-1:0]};
    end
  end

  AST_STAGE_FOLLOW: assert property (@(posedge clk) disable iff (rst)
    prod_v |=> (tw_out == $past(tw_mid)));  // R5
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!prod_v && !$past(rst)) |=> $stable(sq_out));  // R7
endmodule

// File: rtl/hkey_precompute.sv
module hkey_precompute
  import hkp_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [127:0] key_in,
  output logic         key_valid,
  output logic [127:0] tw_key,
  output logic [127:0] helper_key,
  output logic [127:0] sq_key
);
  logic           tw_v;
  logic [BLK-1:0] tw_q;
  logic           prod_v;
  logic           done_evt;

  hkp_twist u_twist (
    .clk    (clk),
    .rst    (rst),
    .load   (load),
    .key_in (key_in),
    .tw_v   (tw_v),
    .tw_q   (tw_q)
  );

  hkp_square u_square (
    .clk        (clk),
    .rst        (rst),
    .in_v       (tw_v),
    .tw_in      (tw_q),
    .prod_v     (prod_v),
    .tw_out     (tw_key),
    .helper_out (helper_key),
    .sq_out     (sq_key)
  );

  // last stage finishing with no newer key behind it
  assign done_evt = prod_v && !tw_v && !load;

  always_ff @(posedge clk) begin
    if (rst)           key_valid <= 1'b0;
    else if (load)     key_valid <= 1'b0;
    else if (done_evt) key_valid <= 1'b1;
  end

  AST_RESET_CLEAR: assert property (@(posedge clk)
    $past(rst) |-> (!key_valid && tw_key == '0 && sq_key == '0 && helper_key == '0));  // R1
  AST_LOAD_DROPS: assert property (@(posedge clk) disable iff (rst)
    load |=> !key_valid);  // R6
  AST_RISE_LATENCY: assert property (@(posedge clk) disable iff (rst)
    $rose(key_valid) |-> ($past(load, 3) && !$past(load, 2) && !$past(load, 1)));  // R5
  AST_VALID_HOLD: assert property (@(posedge clk) disable iff (rst)
    (key_valid && !load) |=> (key_valid && $stable(tw_key) && $stable(sq_key)
                              && $stable(helper_key)));  // R7
endmodule

// File: tb/hkey_precompute_bench.sv
module hkey_precompute_bench;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         load = 1'b0;
  logic [127:0] key_in = '0;
  logic         key_valid;
  logic [127:0] tw_key, helper_key, sq_key;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  hkey_precompute u_hkey_precompute (
    .clk(clk), .rst(rst), .load(load), .key_in(key_in),
    .key_valid(key_valid), .tw_key(tw_key), .helper_key(helper_key), .sq_key(sq_key)
  );

  always #10 clk = ~clk;  // 50 MHz

  function automatic logic [127:0] model_twist(input logic [127:0] k);
    logic [127:0] s;
    logic [127:0] r;
    s = {k[63:0], k[127:64]};
    r = s << 1;
    if (s[127]) r = r ^ 128'hC2000000000000000000000000000001;
    return r;
  endfunction

  // bit-serial Montgomery product a*b*x^-128 mod Q
  function automatic logic [127:0] model_mont(input logic [127:0] a, input logic [127:0] b);
    logic [128:0] r;
    logic [128:0] q;
    q = (129'd1 << 128) | (129'd1 << 127) | (129'd1 << 126) | (129'd1 << 121) | 129'd1;
    r = '0;
    for (int i = 0; i < 128; i++) begin
      if (b[i]) r = r ^ {1'b0, a};
      if (r[0]) r = r ^ q;
      r = r >> 1;
    end
    return r[127:0];
  endfunction

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_outputs(input logic [127:0] k);
    logic [127:0] t, q, h;
    t = model_twist(k);
    q = model_mont(t, t);
    h = {q[63:0] ^ q[127:64], t[63:0] ^ t[127:64]};
    check("R5 valid", 128'(key_valid), 128'd1);
    check("R2 twist", tw_key, t);
    check("R3 square", sq_key, q);
    check("R4 helper", helper_key, h);
  endtask

  // load at the next edge, then follow the latency
  task automatic run_key(input logic [127:0] k);
    key_in = k;
    load   = 1'b1;
    @(negedge clk);
    load   = 1'b0;
    check("R6 drop", 128'(key_valid), 128'd0);
    @(negedge clk);
    check("R5 early", 128'(key_valid), 128'd0);
    @(negedge clk);
    check_outputs(k);
  endtask

  initial begin
    logic [127:0] pat;
    @(negedge clk);
    @(negedge clk);
    check("R1 valid", 128'(key_valid), 128'd0);
    check("R1 tw", tw_key, '0);
    check("R1 helper", helper_key, '0);
    check("R1 square", sq_key, '0);
    rst = 1'b0;
    @(negedge clk);

    for (int b = 0; b < 128; b++) run_key(128'd1 << b);
    run_key('0);
    run_key('1);
    pat = 128'h66e94bd4ef8a2c3b884cfa59ca342b2e;
    for (int i = 0; i < 12; i++) begin
      run_key(pat);
      pat = {pat[126:0], pat[127] ^ pat[125] ^ pat[100] ^ pat[98]} ^ 128'h9e3779b97f4a7c15f39cc0605cedc834;
    end

    // R6: reload one cycle after a load
    key_in = 128'h0123456789abcdeffedcba9876543210;
    load = 1'b1;
    @(negedge clk);
    key_in = 128'hb83b533708bf535d0aa6e52980d53b78;
    @(negedge clk);
    load = 1'b0;
    check("R6 restart drop", 128'(key_valid), 128'd0);
    @(negedge clk);
    check("R6 restart early", 128'(key_valid), 128'd0);
    @(negedge clk);
    check_outputs(128'hb83b533708bf535d0aa6e52980d53b78);

    // R7: key change without load, long hold
    key_in = 128'hffff0000ffff0000aaaa5555aaaa5555;
    for (int i = 0; i < 6; i++) @(negedge clk);
    check("R7 hold valid", 128'(key_valid), 128'd1);
    check("R7 hold tw", tw_key, model_twist(128'hb83b533708bf535d0aa6e52980d53b78));
    check("R7 hold square", sq_key,
          model_mont(model_twist(128'hb83b533708bf535d0aa6e52980d53b78),
                     model_twist(128'hb83b533708bf535d0aa6e52980d53b78)));

    // R1: reset in the middle of a computation
    key_in = 128'h1;
    load = 1'b1;
    @(negedge clk);
    load = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    check("R1 mid valid", 128'(key_valid), 128'd0);
    check("R1 mid tw", tw_key, '0);
    check("R1 mid square", sq_key, '0);
    rst = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check("R1 no stale result", 128'(key_valid), 128'd0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule